// File: doc/BRIEF.md
# Segment Address Translator

This block turns a segmented virtual address into a physical address. A requester presents a segment number, a displacement and the kind of access it wants (data read, data write or instruction fetch). The segment number selects one entry of a small on-chip descriptor table. Each entry holds a presence flag, a set of permission flags, an upper bound on the displacement and a base address. The block checks the entry, then adds the displacement to the base.

Every lookup produces one registered result one clock later. The result is either a clean physical address or a 2-bit fault code. The physical address is forced to zero whenever a fault is reported. A separate write port loads or replaces one descriptor per cycle. Because segments differ in size, each descriptor carries its own bound.

Top module: `seg_xlate_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, every descriptor becomes absent and `res_valid`, `res_fault` and `res_paddr` become zero.
- R2: `res_valid` is high in exactly the cycle after a cycle in which `lk_valid` was sampled high, so the result latency is one clock.
- R3: A lookup that selects an absent descriptor reports fault code 1, whatever its displacement and access kind.
- R4: A lookup that selects a present descriptor whose bound is smaller than the displacement reports fault code 2. The check passes when the displacement is equal to the bound.
- R5: A lookup that passes R3 and R4 reports fault code 3 if its access kind is not permitted. The access kind is encoded as 0 read, 1 write, 2 fetch and 3 reserved. Permission bit 0 allows read, bit 1 allows write and bit 2 allows fetch. Reserved kind 3 is never permitted.
- R6: A lookup with no fault reports fault code 0 and `res_paddr` equal to base plus displacement, taken modulo 2^24.
- R7: Whenever `res_fault` is non-zero, `res_paddr` is zero.
- R8: A descriptor write and a lookup of the same segment in the same cycle: the lookup sees the old descriptor, and the next lookup sees the new one.
- R9: In a cycle where `res_valid` is low, `res_fault` and `res_paddr` are zero.
- R10: A write changes only the descriptor it names. A write with `wr_present` low makes that descriptor absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_seg | input | 4 | Segment number of the lookup |
| lk_disp | input | 16 | Displacement within the segment |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 reserved |
| wr_en | input | 1 | Descriptor write strobe |
| wr_seg | input | 4 | Descriptor being written |
| wr_present | input | 1 | Presence flag to store |
| wr_perm | input | 3 | Permission flags to store (bit0 read, bit1 write, bit2 fetch) |
| wr_bound | input | 16 | Largest legal displacement to store |
| wr_base | input | 24 | Segment base address to store |
| res_valid | output | 1 | Result valid, one cycle after the lookup |
| res_fault | output | 2 | 0 none, 1 absent, 2 out of bounds, 3 access denied |
| res_paddr | output | 24 | Physical address, zero on any fault |

## Verification
The hardest situations to reach from the ports are the ones where the fault causes compete: an absent descriptor that also has a displacement out of bounds, or a bound violation that also carries a forbidden access kind. The bench reaches them by loading every descriptor with a different bound and permission pattern, leaving two of them absent. It then sweeps every segment against all four access kinds and against displacements of zero, exactly the bound, one past the bound and all ones. The write/lookup collision of R8 needs both ports driven at the same edge for the same segment, so the bench issues the two together and then repeats the lookup alone.

// File: rtl/seg_xlate_pkg.sv
// Package seg_xlate_pkg
// Shared encodings for the segment translator: fault codes, access kinds
// and the permission test. Assumes three permission flags per descriptor.
package seg_xlate_pkg;

    localparam int PERM_W = 3;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_RANGE  = 2'd2,
        FLT_ACCESS = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    // True when the permission flags allow the given access kind.
    function automatic logic acc_permitted(input logic [PERM_W-1:0] perm,
                                           input logic [1:0] acc);
        logic ok;
        case (acc)
            ACC_LOAD:  ok = perm[0];
            ACC_STORE: ok = perm[1];
            ACC_FETCH: ok = perm[2];
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/seg_table.sv
// Module seg_table
// Descriptor storage. It has one write port and one combinational read port.
// A write lands at the clock edge, so a read in the same cycle returns the
// previous contents. Assumes reset is synchronous and active low, and that
// reset clears every presence flag.
module seg_table #(
    parameter int SEG_W  = 4,
    parameter int DISP_W = 16,
    parameter int BASE_W = 24,
    parameter int PERM_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEG_W-1:0]  wr_seg,
    input  logic              wr_present,
    input  logic [PERM_W-1:0] wr_perm,
    input  logic [DISP_W-1:0] wr_bound,
    input  logic [BASE_W-1:0] wr_base,
    input  logic [SEG_W-1:0]  rd_seg,
    output logic              rd_present,
    output logic [PERM_W-1:0] rd_perm,
    output logic [DISP_W-1:0] rd_bound,
    output logic [BASE_W-1:0] rd_base
);

    localparam int DEPTH = 1 << SEG_W;

    logic [DEPTH-1:0]  present_vec;
    logic [PERM_W-1:0] perm_arr  [DEPTH];
    logic [DISP_W-1:0] bound_arr [DEPTH];
    logic [BASE_W-1:0] base_arr  [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_ent
            logic              e_present;
            logic [PERM_W-1:0] e_perm;
            logic [DISP_W-1:0] e_bound;
            logic [BASE_W-1:0] e_base;
            logic              e_hit;

            assign e_hit = wr_en && (wr_seg == SEG_W'(g));

            // Hold one descriptor; cleared by reset, replaced on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    e_present <= 1'b0;
                    e_perm    <= '0;
                    e_bound   <= '0;
                    e_base    <= '0;
                end else if (e_hit) begin
                    e_present <= wr_present;
                    e_perm    <= wr_perm;
                    e_bound   <= wr_bound;
                    e_base    <= wr_base;
                end
            end

            assign present_vec[g] = e_present;
            assign perm_arr[g]    = e_perm;
            assign bound_arr[g]   = e_bound;
            assign base_arr[g]    = e_base;
        end
    endgenerate

    // Read selection by segment number.
    always_comb begin
        rd_present = present_vec[rd_seg];
        rd_perm    = perm_arr[rd_seg];
        rd_bound   = bound_arr[rd_seg];
        rd_base    = base_arr[rd_seg];
    end

endmodule

// File: rtl/seg_guard.sv
// Module seg_guard
// Decides the fault outcome of one lookup from the selected descriptor.
// The causes are ranked: absent first, then bound, then access permission.
// Assumes the descriptor fields are already selected for the lookup.
module seg_guard #(
    parameter int DISP_W = 16,
    parameter int PERM_W = 3
) (
    input  logic              ent_present,
    input  logic [PERM_W-1:0] ent_perm,
    input  logic [DISP_W-1:0] ent_bound,
    input  logic [DISP_W-1:0] disp,
    input  logic [1:0]        acc,
    output logic [1:0]        fault
);
    import seg_xlate_pkg::*;

    logic over_bound;
    logic denied;

    assign over_bound = disp > ent_bound;
    assign denied     = !acc_permitted(ent_perm, acc);

    // Rank the fault causes.
    always_comb begin
        if (!ent_present)    fault = FLT_ABSENT;
        else if (over_bound) fault = FLT_RANGE;
        else if (denied)     fault = FLT_ACCESS;
        else                 fault = FLT_NONE;
    end

endmodule

// File: rtl/seg_sum.sv
// Module seg_sum
// Forms base plus displacement at the width of the base. A carry out of the
// top bit is dropped, so the address wraps. Assumes the displacement is
// unsigned and no wider than the base; a wider displacement is cut to base width.
module seg_sum #(
    parameter int DISP_W = 16,
    parameter int BASE_W = 24
) (
    input  logic [BASE_W-1:0] base,
    input  logic [DISP_W-1:0] disp,
    output logic [BASE_W-1:0] paddr
);

    generate
        if (DISP_W < BASE_W) begin : g_ext
            // Zero-extend the displacement before the add.
            assign paddr = base + {{(BASE_W-DISP_W){1'b0}}, disp};
        end else begin : g_cut
            // Keep only the low bits of a wide displacement.
            assign paddr = base + disp[BASE_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/seg_xlate_unit.sv
// Module seg_xlate_unit
// Segment translator top level. A lookup selects a descriptor. The unit then
// checks the descriptor and adds the displacement to its base, and registers
// the outcome one clock later. Assumes a single clock and a synchronous
// active-low reset.
module seg_xlate_unit #(
    parameter int SEG_W  = 4,
    parameter int DISP_W = 16,
    parameter int BASE_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [SEG_W-1:0]  lk_seg,
    input  logic [DISP_W-1:0] lk_disp,
    input  logic [1:0]        lk_acc,
    input  logic              wr_en,
    input  logic [SEG_W-1:0]  wr_seg,
    input  logic              wr_present,
    input  logic [2:0]        wr_perm,
    input  logic [DISP_W-1:0] wr_bound,
    input  logic [BASE_W-1:0] wr_base,
    output logic              res_valid,
    output logic [1:0]        res_fault,
    output logic [BASE_W-1:0] res_paddr
);
    import seg_xlate_pkg::*;

    logic              tbl_present;
    logic [PERM_W-1:0] tbl_perm;
    logic [DISP_W-1:0] tbl_bound;
    logic [BASE_W-1:0] tbl_base;
    logic [1:0]        fault_c;
    logic [BASE_W-1:0] sum_c;

    seg_table #(
        .SEG_W (SEG_W),
        .DISP_W(DISP_W),
        .BASE_W(BASE_W),
        .PERM_W(PERM_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_seg    (wr_seg),
        .wr_present(wr_present),
        .wr_perm   (wr_perm),
        .wr_bound  (wr_bound),
        .wr_base   (wr_base),
        .rd_seg    (lk_seg),
        .rd_present(tbl_present),
        .rd_perm   (tbl_perm),
        .rd_bound  (tbl_bound),
        .rd_base   (tbl_base)
    );

    seg_guard #(
        .DISP_W(DISP_W),
        .PERM_W(PERM_W)
    ) u_guard (
        .ent_present(tbl_present),
        .ent_perm   (tbl_perm),
        .ent_bound  (tbl_bound),
        .disp       (lk_disp),
        .acc        (lk_acc),
        .fault      (fault_c)
    );

    seg_sum #(
        .DISP_W(DISP_W),
        .BASE_W(BASE_W)
    ) u_sum (
        .base (tbl_base),
        .disp (lk_disp),
        .paddr(sum_c)
    );

    // Register the lookup outcome; quiet when no lookup or any fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_fault <= FLT_NONE;
            res_paddr <= '0;
        end else begin
            res_valid <= lk_valid;
            if (lk_valid) begin
                res_fault <= fault_c;
                res_paddr <= (fault_c == FLT_NONE) ? sum_c : '0;
            end else begin
                res_fault <= FLT_NONE;
                res_paddr <= '0;
            end
        end
    end

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (res_valid == $past(lk_valid)));                      // R2

    AST_ABSENT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !tbl_present) |=> (res_fault == FLT_ABSENT));             // R3

    AST_BOUND_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && tbl_present && (lk_disp > tbl_bound)) |=> (res_fault == FLT_RANGE)); // R4

    AST_CLEAN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && res_valid && (res_fault == FLT_NONE))
            |-> (res_paddr == $past(tbl_base + BASE_W'(lk_disp))));           // R6

    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (res_fault != FLT_NONE) |-> (res_paddr == '0));                        // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> ((res_fault == FLT_NONE) && (res_paddr == '0)));        // R9

endmodule

// File: tb/sim_seg_xlate_unit.sv
module sim_seg_xlate_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [3:0]  lk_seg = '0;
    logic [15:0] lk_disp = '0;
    logic [1:0]  lk_acc = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_seg = '0;
    logic        wr_present = 1'b0;
    logic [2:0]  wr_perm = '0;
    logic [15:0] wr_bound = '0;
    logic [23:0] wr_base = '0;
    logic        res_valid;
    logic [1:0]  res_fault;
    logic [23:0] res_paddr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic        m_present [16];
    logic [2:0]  m_perm    [16];
    logic [15:0] m_bound   [16];
    logic [23:0] m_base    [16];

    always #2.5 clk = ~clk;

    seg_xlate_unit u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_seg(lk_seg), .lk_disp(lk_disp), .lk_acc(lk_acc),
        .wr_en(wr_en), .wr_seg(wr_seg), .wr_present(wr_present), .wr_perm(wr_perm),
        .wr_bound(wr_bound), .wr_base(wr_base),
        .res_valid(res_valid), .res_fault(res_fault), .res_paddr(res_paddr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected fault from the ranking in R3, R4, R5.
    function automatic logic [1:0] exp_fault(input logic [3:0] s, input logic [15:0] d,
                                             input logic [1:0] a);
        if (!m_present[s]) return 2'd1;
        if (d > m_bound[s]) return 2'd2;
        if (a == 2'd3 || !m_perm[s][a]) return 2'd3;
        return 2'd0;
    endfunction

    function automatic logic [23:0] exp_addr(input logic [3:0] s, input logic [15:0] d,
                                             input logic [1:0] a);
        if (exp_fault(s, d, a) != 2'd0) return 24'h0;
        return m_base[s] + {8'h00, d};
    endfunction

    task automatic do_write(input logic [3:0] s, input logic p, input logic [2:0] pm,
                            input logic [15:0] b, input logic [23:0] bs);
        @(negedge clk);
        wr_en = 1'b1; wr_seg = s; wr_present = p; wr_perm = pm; wr_bound = b; wr_base = bs;
        @(posedge clk); #1;
        wr_en = 1'b0;
        m_present[s] = p; m_perm[s] = pm; m_bound[s] = b; m_base[s] = bs;
    endtask

    task automatic do_look(input string req, input logic [3:0] s, input logic [15:0] d,
                           input logic [1:0] a);
        logic [1:0]  ef;
        logic [23:0] ea;
        ef = exp_fault(s, d, a);
        ea = exp_addr(s, d, a);
        @(negedge clk);
        lk_valid = 1'b1; lk_seg = s; lk_disp = d; lk_acc = a;
        @(posedge clk); #1;
        lk_valid = 1'b0;
        chk({req, " valid"}, 32'(res_valid), 32'd1);
        chk({req, " fault"}, 32'(res_fault), 32'(ef));
        chk({req, " paddr"}, 32'(res_paddr), 32'(ea));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_present[i] = 1'b0; m_perm[i] = '0; m_bound[i] = '0; m_base[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state of outputs
        chk("R1 res_valid", 32'(res_valid), 32'd0);
        chk("R1 res_fault", 32'(res_fault), 32'd0);
        chk("R1 res_paddr", 32'(res_paddr), 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // R1: every descriptor absent after reset
        for (int s = 0; s < 16; s++) do_look("R1 absent after reset", 4'(s), 16'h0000, 2'd0);

        // Load descriptors: 14 written absent, 15 never written
        for (int s = 0; s < 15; s++)
            do_write(4'(s), (s != 14), 3'(s), 16'(s * 16'h0FA0 + 16'h0010), 24'(s * 24'h0F4321));

        // R2, R9: idle cycle is quiet
        @(negedge clk); @(posedge clk); #1;
        chk("R2 idle valid", 32'(res_valid), 32'd0);
        chk("R9 idle fault", 32'(res_fault), 32'd0);
        chk("R9 idle paddr", 32'(res_paddr), 32'd0);

        // R3 R4 R5 R6 R7: sweep segments, access kinds and boundary displacements
        for (int s = 0; s < 16; s++) begin
            for (int a = 0; a < 4; a++) begin
                do_look("R3/R4/R5/R6 sweep d=0", 4'(s), 16'h0000, 2'(a));
                do_look("R4 sweep d=bound", 4'(s), m_bound[s], 2'(a));
                do_look("R4 sweep d=bound+1", 4'(s), m_bound[s] + 16'd1, 2'(a));
                do_look("R7 sweep d=max", 4'(s), 16'hFFFF, 2'(a));
            end
        end

        // R6: address wraps modulo 2^24
        do_write(4'd9, 1'b1, 3'b111, 16'hFFFF, 24'hFFFF00);
        do_look("R6 wrap", 4'd9, 16'h0200, 2'd1);
        chk("R6 wrap value", 32'(res_paddr), 32'h000100);

        // R10: neighbours unchanged by the write above
        do_look("R10 neighbour 8", 4'd8, 16'h0004, 2'd0);
        do_look("R10 neighbour 10", 4'd10, 16'h0004, 2'd1);

        // R8: same-cycle write and lookup of segment 3
        begin
            logic [1:0]  of;
            logic [23:0] oa;
            of = exp_fault(4'd3, 16'h0020, 2'd0);
            oa = exp_addr(4'd3, 16'h0020, 2'd0);
            @(negedge clk);
            lk_valid = 1'b1; lk_seg = 4'd3; lk_disp = 16'h0020; lk_acc = 2'd0;
            wr_en = 1'b1; wr_seg = 4'd3; wr_present = 1'b1; wr_perm = 3'b000;
            wr_bound = 16'h0010; wr_base = 24'h123456;
            @(posedge clk); #1;
            lk_valid = 1'b0; wr_en = 1'b0;
            chk("R8 old fault", 32'(res_fault), 32'(of));
            chk("R8 old paddr", 32'(res_paddr), 32'(oa));
            m_present[3] = 1'b1; m_perm[3] = 3'b000; m_bound[3] = 16'h0010; m_base[3] = 24'h123456;
            do_look("R8 new descriptor", 4'd3, 16'h0020, 2'd0);
            chk("R8 new fault range", 32'(res_fault), 32'd2);
        end

        // R10: write absent removes a descriptor
        do_write(4'd5, 1'b0, 3'b111, 16'hFFFF, 24'h000100);
        do_look("R10 removed", 4'd5, 16'h0000, 2'd0);

        // R5: fetch-only and read-only descriptors
        do_write(4'd7, 1'b1, 3'b100, 16'h00FF, 24'h400000);
        do_look("R5 fetch-only fetch", 4'd7, 16'h0010, 2'd2);
        do_look("R5 fetch-only read", 4'd7, 16'h0010, 2'd0);
        do_write(4'd6, 1'b1, 3'b001, 16'h00FF, 24'h500000);
        do_look("R5 read-only write", 4'd6, 16'h0010, 2'd1);
        do_look("R5 read-only read", 4'd6, 16'h00FF, 2'd0);

        // R1: reset in the middle clears the table
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R1 mid reset valid", 32'(res_valid), 32'd0);
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 16; i++) m_present[i] = 1'b0;
        do_look("R1 cleared after reset", 4'd6, 16'h0000, 2'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule